// File: doc/BRIEF.md
# Rotating-Mask Masked AES S-box Unit

This unit performs the AES byte substitution on data that is never carried in the clear. Every byte that enters is additively masked: it has been XORed with one of sixteen fixed mask bytes. Every byte that leaves is masked with the following mask in the set. The unit holds sixteen masked substitution tables, one for each mask. Table k takes `x ^ M[k]` and returns `S(x) ^ M[(k+1) mod 16]`. Because the removal of the input mask and the application of the output mask both happen inside each table, the plain value `x` and the plain value `S(x)` never sit on a wire at the lookup boundary.

A rotating index chooses which table answers. A one-cycle `start` pulse loads the index from `offset`. After that, each accepted byte moves the index forward by one, wrapping from 15 to 0. The index that the next input must be masked with is always shown on `exp_midx`. Each result leaves with the index of its own output mask, so a downstream stage can remove or track that mask.

Inputs use a valid/ready handshake, and so do outputs. The output is a single register stage controlled by a two-state machine. In `OS_EMPTY` the register holds nothing. A load moves it to `OS_FULL`. In `OS_FULL` it stays full while the consumer stalls or while a new byte is loaded in the same cycle. It returns to `OS_EMPTY` when the consumer takes the result and no new byte arrives.

Top module: `rot_mask_sbox`

## Requirements
- R1: After reset, `exp_midx` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: A cycle with `start` high loads `offset` into the index, so `exp_midx` equals `offset` in the next cycle. During the start cycle `in_ready` is 0, and a byte presented in that cycle is not accepted.
- R3: Each accepted byte (`in_valid && in_ready` at a clock edge) advances `exp_midx` by one modulo 16, so 15 is followed by 0.
- R4: The mask set M[0..15] is 5A, C3, 17, E8, 29, 9D, 74, B0, 0F, 63, D6, 48, F1, 8E, 35, AA (hex), listed in index order.
- R5: For a byte accepted while `exp_midx` = k, `out_midx` is (k+1) mod 16 and `out_byte` equals `S(in_byte ^ M[k]) ^ M[(k+1) mod 16]`. This holds for all 256 plain values and every starting offset.
- R6: `out_valid` rises in the cycle after an accept, which is one register stage of latency.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. During that time `out_byte` and `out_midx` hold their values, and the index does not advance even if `in_valid` is high.
- R8: When the consumer takes a result and no new byte is accepted, `out_valid` falls in the next cycle. Idle cycles with `in_valid` low leave the index unchanged.
- R9: S is the AES S-box: S(00)=63, S(01)=7C, S(53)=ED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load pulse for the starting mask index |
| offset | input | 4 | Starting mask index loaded on `start` |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Unit can accept an input byte |
| in_byte | input | 8 | Input byte masked with M[exp_midx] |
| exp_midx | output | 4 | Index of the mask the next input must carry |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_byte | output | 8 | Substituted byte masked with M[out_midx] |
| out_midx | output | 4 | Index of the mask on `out_byte` |

## Verification
Assertions check the following on every cycle: the index loads from `offset` on `start`, the index steps by exactly one per accepted byte and holds otherwise, a result appears one cycle after each accept carrying the next mask index, and the output register with its blocked `in_ready` stays frozen during a stall. These properties cannot show that the masked tables compute the right values. Only the bench's scenarios can do that. The bench sweeps all 256 plain bytes under all sixteen starting offsets, compares the unmasked results with an S-box built by inverse search, and also checks three fixed S-box values, the start-cycle priority and the drain to empty.

// File: rtl/rms_pkg.sv
`timescale 1ns/1ps
package rms_pkg;

    localparam int N_MASK = 16;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(N_MASK);

    // index 0 sits in the low byte
    localparam logic [N_MASK*BYTE_W-1:0] RMS_MASK_VEC = {
        8'hAA, 8'h35, 8'h8E, 8'hF1, 8'h48, 8'hD6, 8'h63, 8'h0F,
        8'hB0, 8'h74, 8'h9D, 8'h29, 8'hE8, 8'h17, 8'hC3, 8'h5A
    };

    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } os_state_t;

    function automatic logic [BYTE_W-1:0] mask_at(input int k);
        return RMS_MASK_VEC[k*BYTE_W +: BYTE_W];
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
        end
        return acc;
    endfunction

    // a^254 is the field inverse, and 0 maps to 0
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] res;
        logic [7:0] pw;
        logic [7:0] ex;
        res = 8'h01;
        pw  = a;
        ex  = 8'hFE;
        for (int i = 0; i < 8; i++) begin
            if (ex[i]) res = gf_mul(res, pw);
            pw = gf_mul(pw, pw);
        end
        return res;
    endfunction

    function automatic logic [7:0] aes_sub(input logic [7:0] a);
        logic [7:0] v;
        logic [7:0] r;
        logic [7:0] c;
        v = gf_inv(a);
        c = 8'h63;
        for (int i = 0; i < 8; i++) begin
            r[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ c[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/rms_index_ctrl.sv
`timescale 1ns/1ps
module rms_index_ctrl
    import rms_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IDX_W-1:0] offset_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= '0;
        else if (load_i) idx_q <= offset_i;
        else if (step_i) idx_q <= idx_q + IDX_W'(1);
    end

    assign idx_o = idx_q;

    // R2
    load_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> idx_q == $past(offset_i));

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> idx_q == $past(idx_q) + IDX_W'(1));

    // R8
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(idx_q));

endmodule

// File: rtl/rms_masked_table.sv
`timescale 1ns/1ps
module rms_masked_table
    import rms_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MASK_IN  = 8'h00,
    parameter logic [BYTE_W-1:0] MASK_OUT = 8'h00
) (
    input  logic [BYTE_W-1:0] din_i,
    output logic [BYTE_W-1:0] dout_o
);

    // removal of the input mask and application of the output mask both fold into one table
    always_comb begin
        dout_o = aes_sub(din_i ^ MASK_IN) ^ MASK_OUT;
    end

endmodule

// File: rtl/rms_out_stage.sv
`timescale 1ns/1ps
module rms_out_stage
    import rms_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              drain_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [IDX_W-1:0]  midx_i,
    output logic              valid_o,
    output logic              stall_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic [IDX_W-1:0]  midx_o
);

    os_state_t         state_q;
    os_state_t         state_d;
    logic [BYTE_W-1:0] byte_q;
    logic [IDX_W-1:0]  midx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OS_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_EMPTY: state_d = load_i ? OS_FULL : OS_EMPTY;
            OS_FULL:  state_d = (load_i || !drain_i) ? OS_FULL : OS_EMPTY;
            default:  state_d = OS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            midx_q <= '0;
        end else if (load_i) begin
            byte_q <= byte_i;
            midx_q <= midx_i;
        end
    end

    always_comb begin
        valid_o = (state_q == OS_FULL);
        stall_o = (state_q == OS_FULL) && !drain_i;
        byte_o  = byte_q;
        midx_o  = midx_q;
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !drain_i) |=> valid_o && $stable(byte_o) && $stable(midx_o));

    // R8
    drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && drain_i && !load_i) |=> !valid_o);

endmodule

// File: rtl/rot_mask_sbox.sv
`timescale 1ns/1ps
module rot_mask_sbox
    import rms_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  offset,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [IDX_W-1:0]  exp_midx,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic [IDX_W-1:0]  out_midx
);

    logic              accept;
    logic              stalled;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  idx_next;
    logic [BYTE_W-1:0] sel_byte;
    logic [BYTE_W-1:0] tbl_q [N_MASK];

    assign in_ready = !start && !stalled;
    assign accept   = in_valid && in_ready;
    assign exp_midx = idx;
    assign idx_next = idx + IDX_W'(1);

    rms_index_ctrl u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (start),
        .offset_i (offset),
        .step_i   (accept),
        .idx_o    (idx)
    );

    generate
        for (genvar g = 0; g < N_MASK; g++) begin : g_tbl
            rms_masked_table #(
                .MASK_IN  (mask_at(g)),
                .MASK_OUT (mask_at((g + 1) % N_MASK))
            ) u_tbl (
                .din_i  (in_byte),
                .dout_o (tbl_q[g])
            );
        end
    endgenerate

    assign sel_byte = tbl_q[idx];

    rms_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .drain_i (out_ready),
        .byte_i  (sel_byte),
        .midx_i  (idx_next),
        .valid_o (out_valid),
        .stall_o (stalled),
        .byte_o  (out_byte),
        .midx_o  (out_midx)
    );

    // R6
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    // R5
    out_midx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_midx == $past(exp_midx) + IDX_W'(1));

    // R7
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R2
    start_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !in_ready);

endmodule

// File: tb/test_rot_mask_sbox.sv
`timescale 1ns/1ps
module test_rot_mask_sbox;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] offset = 4'd0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = 8'h00;
    logic [3:0] exp_midx;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_byte;
    logic [3:0] out_midx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rot_mask_sbox i_rot_mask_sbox (
        .clk, .rst_n, .start, .offset, .in_valid, .in_ready, .in_byte,
        .exp_midx, .out_valid, .out_ready, .out_byte, .out_midx
    );

    // mask values as listed in R4
    function automatic logic [7:0] m_of(input int k);
        case (k % 16)
            0: return 8'h5A;  1: return 8'hC3;  2: return 8'h17;  3: return 8'hE8;
            4: return 8'h29;  5: return 8'h9D;  6: return 8'h74;  7: return 8'hB0;
            8: return 8'h0F;  9: return 8'h63; 10: return 8'hD6; 11: return 8'h48;
           12: return 8'hF1; 13: return 8'h8E; 14: return 8'h35; default: return 8'hAA;
        endcase
    endfunction

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        logic [7:0] y = b;
        while (y != 0) begin
            if (y[0]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
            y = y >> 1;
        end
        return p;
    endfunction

    function automatic logic [7:0] rotl(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    function automatic logic [7:0] ref_sbox(input logic [7:0] a);
        logic [7:0] inv = 8'h00;
        for (int c = 1; c < 256; c++)
            if (a != 0 && fmul(a, 8'(c)) == 8'h01) inv = 8'(c);
        return inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
    endfunction

    logic [7:0] sref [256];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(exp_midx == 4'd0, "R1 index", int'(exp_midx), 0);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    endtask

    task automatic do_start(input int o);
        @(negedge clk);
        start = 1'b1;
        offset = 4'(o);
        #1;
        chk(in_ready == 1'b0, "R2 in_ready during start", int'(in_ready), 0);
        @(negedge clk);
        start = 1'b0;
        chk(exp_midx == 4'(o), "R2 offset load", int'(exp_midx), o);
    endtask

    // presents plain x masked with M[ek], checks result one cycle later
    task automatic push_check(input int x, input int ek);
        int nk = (ek + 1) % 16;
        chk(exp_midx == 4'(ek), "R3 index before push", int'(exp_midx), ek);
        in_byte = 8'(x) ^ m_of(ek);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R6 out_valid after accept", int'(out_valid), 1);
        chk(out_midx == 4'(nk), "R5 out_midx", int'(out_midx), nk);
        chk((out_byte ^ m_of(nk)) == sref[x], "R5 unmasked result",
            int'(out_byte ^ m_of(nk)), int'(sref[x]));
        chk(exp_midx == 4'(nk), "R3 index advance", int'(exp_midx), nk);
    endtask

    task automatic t_known();
        logic [7:0] pv [3] = '{8'h00, 8'h01, 8'h53};
        logic [7:0] ev [3] = '{8'h63, 8'h7C, 8'hED};
        do_start(0);
        for (int i = 0; i < 3; i++) begin
            in_byte = pv[i] ^ m_of(i);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk((out_byte ^ m_of(i + 1)) == ev[i], "R9 known S-box value",
                int'(out_byte ^ m_of(i + 1)), int'(ev[i]));
        end
    endtask

    task automatic t_sweep();
        for (int o = 0; o < 16; o++) begin
            do_start(o);
            for (int x = 0; x < 256; x++) push_check(x, (o + x) % 16);
        end
    endtask

    task automatic t_start_priority();
        @(negedge clk);
        @(negedge clk);
        start = 1'b1;
        offset = 4'd9;
        in_valid = 1'b1;
        in_byte = 8'h44;
        @(negedge clk);
        start = 1'b0;
        in_valid = 1'b0;
        chk(exp_midx == 4'd9, "R2 start wins over input", int'(exp_midx), 9);
        chk(out_valid == 1'b0, "R2 start-cycle byte not accepted", int'(out_valid), 0);
    endtask

    task automatic t_stall();
        logic [7:0] eb;
        do_start(5);
        out_ready = 1'b0;
        in_byte = 8'h11 ^ m_of(5);
        in_valid = 1'b1;
        @(negedge clk);
        eb = sref[8'h11] ^ m_of(6);
        in_byte = 8'h22;
        #1;
        chk(out_valid == 1'b1, "R7 result held", int'(out_valid), 1);
        chk(in_ready == 1'b0, "R7 in_ready low in stall", int'(in_ready), 0);
        repeat (2) @(negedge clk);
        chk(out_byte == eb, "R7 out_byte stable", int'(out_byte), int'(eb));
        chk(out_midx == 4'd6, "R7 out_midx stable", int'(out_midx), 6);
        chk(exp_midx == 4'd6, "R7 index frozen", int'(exp_midx), 6);
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 drain to empty", int'(out_valid), 0);
        repeat (3) @(negedge clk);
        chk(exp_midx == 4'd6, "R8 idle leaves index", int'(exp_midx), 6);
        chk(out_valid == 1'b0, "R8 idle stays empty", int'(out_valid), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) sref[i] = ref_sbox(8'(i));
        t_reset();
        t_known();
        t_start_priority();
        t_stall();
        t_sweep();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule